// File: doc/BRIEF.md
# SPI Master Register Front-End

This block is the memory-mapped control face of an SPI master. It sits behind a 32-bit AXI4-Lite slave port and owns the control word, the chip-select word and three interrupt registers: the global gate, the pending flags and the per-source mask. Values that belong to the shift engine and its FIFOs are not stored here. The engine supplies a status word, two fill counts and the received word on sideband inputs, and this block makes them readable on the bus.

Bus accesses to the data offsets become single-cycle strobes toward the engine. A write to the transmit offset pulses a transmit strobe and presents the written word. A read of the receive offset pulses a pop strobe. A software-reset offset accepts a key value. When the key is written, every register returns to its default and a reset pulse is sent out for the rest of the controller. Interrupt sources set pending flags, and software clears or sets a flag by writing a 1 to it, which inverts that flag. The flags, the mask and the global gate are combined into one interrupt line.

Top module: `spi_regfront`

## Requirements
- R1: After reset, control reads 0x180, chip select reads all ones (0xF at the default width), the global gate, pending flags and mask read 0, irq_o is 0, and bvalid and rvalid are 0.
- R2: A write is taken only in a cycle where awvalid and wvalid are both high and no write response is pending. awready and wready rise together in that cycle. A lone awvalid or a lone wvalid is never accepted and changes no register.
- R3: A write replaces the addressed register with the low bits of wdata, whatever the value of wstrb.
- R4: bvalid rises in the cycle after the write handshake and rvalid in the cycle after the read handshake. Each stays high, with its data and response unchanged, until bready or rready is seen.
- R5: A read of an offset with no register returns 0 with response 00 (OKAY). A write there returns 00 and changes nothing.
- R6: Status (0x64), receive data (0x6C) and the fill counts (0x74 transmit, 0x78 receive) read the sideband inputs, zero-extended. Writes to those offsets change nothing.
- R7: Reads of the software-reset offset (0x40) and the transmit-data offset (0x68) return 0.
- R8: The fill-count offsets are mapped only when FIFO_DEPTH is 16 or 256. For any other depth they read 0.
- R9: Writing the pending register (0x20) inverts each bit written as 1 and keeps each bit written as 0.
- R10: An interrupt event input at 1 sets its pending bit at the next edge. This wins over a software inversion of the same bit in the same cycle.
- R11: irq_o is 1 exactly when bit 31 of the global gate (0x1C) is 1 and some pending bit is also 1 in the mask (0x28).
- R12: During the handshake cycle of a write to 0x68, tx_wr_o is 1 and tx_data_o equals wdata. During the handshake cycle of a read of 0x6C, rx_rd_o is 1.
- R13: Writing 0x0000000A to 0x40 returns every register to its reset value and raises soft_rst_o for exactly one cycle, the cycle after the handshake, with response 00. Any other value written there gives response 10 (SLVERR) and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| awaddr | input | ADDR_W | Write byte address |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Byte strobes, ignored |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| bresp | output | 2 | Write response |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| araddr | input | ADDR_W | Read byte address |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| rdata | output | 32 | Read data |
| rresp | output | 2 | Read response |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data ready |
| stat_i | input | STAT_W | Status word from the engine |
| tx_occ_i | input | OCC_W | Transmit FIFO fill count |
| rx_occ_i | input | OCC_W | Receive FIFO fill count |
| rx_data_i | input | 32 | Head of the receive FIFO |
| irq_evt_i | input | IRQ_N | Interrupt event strobes |
| ctrl_o | output | CTRL_W | Control register contents |
| ssel_o | output | SS_W | Chip-select register contents |
| tx_wr_o | output | 1 | Transmit push strobe |
| tx_data_o | output | 32 | Word to push |
| rx_rd_o | output | 1 | Receive pop strobe |
| soft_rst_o | output | 1 | Software reset pulse |
| irq_o | output | 1 | Combined interrupt |

## Verification
Some properties are checked on every cycle. Both ready signals only rise while both valids are present. Responses stay stable under back-pressure and the read response is always OKAY. Events always land in the pending flags, and the flags do not change without a cause. The reset pulse lasts one cycle and shows the registers already at their defaults. Other behaviour can only be shown by the directed scenarios: the value each offset returns, that wstrb is ignored, that writes to read-only and unmapped offsets have no effect, the wrong-key error, the event-over-inversion priority, and whether the fill counts exist at a second FIFO depth.

// File: rtl/spi_rf_pkg.sv
// Shared definitions for the SPI register front-end: byte offsets, the
// register-select code produced by the decoder, response codes and the
// software-reset key. Assumes 32-bit data and word-aligned offsets.
package spi_rf_pkg;

    localparam logic [7:0] OFF_GIE   = 8'h1C;
    localparam logic [7:0] OFF_ISR   = 8'h20;
    localparam logic [7:0] OFF_IER   = 8'h28;
    localparam logic [7:0] OFF_SRST  = 8'h40;
    localparam logic [7:0] OFF_CTRL  = 8'h60;
    localparam logic [7:0] OFF_STAT  = 8'h64;
    localparam logic [7:0] OFF_TXD   = 8'h68;
    localparam logic [7:0] OFF_RXD   = 8'h6C;
    localparam logic [7:0] OFF_SSEL  = 8'h70;
    localparam logic [7:0] OFF_TXOCC = 8'h74;
    localparam logic [7:0] OFF_RXOCC = 8'h78;

    localparam logic [1:0]  RESP_OKAY   = 2'b00;
    localparam logic [1:0]  RESP_SLVERR = 2'b10;
    localparam logic [31:0] SRST_KEY    = 32'h0000_000A;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_SRST,
        SEL_CTRL,
        SEL_STAT,
        SEL_TXD,
        SEL_RXD,
        SEL_SSEL,
        SEL_TXOCC,
        SEL_RXOCC,
        SEL_GIE,
        SEL_ISR,
        SEL_IER
    } reg_sel_e;

endpackage

// File: rtl/spi_rf_decode.sv
// Address decoder: maps a byte address to a register select code.
// Assumes ADDR_W >= 7. The two low address bits are ignored (word access).
// The fill-count offsets decode only when OCC_EN is set.
module spi_rf_decode
    import spi_rf_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter bit OCC_EN = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    logic [ADDR_W-1:0] base;
    logic [1:0]        unused_lsb;

    assign base       = {addr[ADDR_W-1:2], 2'b00};
    assign unused_lsb = addr[1:0];

    // Select the register that owns the word address.
    always_comb begin
        sel = SEL_NONE;
        case (base)
            ADDR_W'(OFF_GIE):   sel = SEL_GIE;
            ADDR_W'(OFF_ISR):   sel = SEL_ISR;
            ADDR_W'(OFF_IER):   sel = SEL_IER;
            ADDR_W'(OFF_SRST):  sel = SEL_SRST;
            ADDR_W'(OFF_CTRL):  sel = SEL_CTRL;
            ADDR_W'(OFF_STAT):  sel = SEL_STAT;
            ADDR_W'(OFF_TXD):   sel = SEL_TXD;
            ADDR_W'(OFF_RXD):   sel = SEL_RXD;
            ADDR_W'(OFF_SSEL):  sel = SEL_SSEL;
            ADDR_W'(OFF_TXOCC): sel = OCC_EN ? SEL_TXOCC : SEL_NONE;
            ADDR_W'(OFF_RXOCC): sel = OCC_EN ? SEL_RXOCC : SEL_NONE;
            default:            sel = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/spi_rf_axi.sv
// AXI4-Lite channel handling. A write is taken only when address and data
// are valid together and no write response is outstanding. A read is taken
// when no read response is outstanding. Responses are registered and held
// until the master accepts them. Assumes that the data and error inputs are
// valid in the handshake cycle.
module spi_rf_axi
    import spi_rf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        awvalid,
    input  logic        wvalid,
    output logic        awready,
    output logic        wready,
    output logic [1:0]  bresp,
    output logic        bvalid,
    input  logic        bready,
    input  logic        arvalid,
    output logic        arready,
    output logic [31:0] rdata,
    output logic [1:0]  rresp,
    output logic        rvalid,
    input  logic        rready,
    input  logic        wr_err_i,
    input  logic [31:0] rd_data_i,
    output logic        wr_fire_o,
    output logic        rd_fire_o
);

    logic        bvalid_q;
    logic [1:0]  bresp_q;
    logic        rvalid_q;
    logic [31:0] rdata_q;

    assign awready   = awvalid && wvalid && !bvalid_q;
    assign wready    = awready;
    assign wr_fire_o = awready;
    assign arready   = !rvalid_q;
    assign rd_fire_o = arvalid && !rvalid_q;

    assign bvalid = bvalid_q;
    assign bresp  = bresp_q;
    assign rvalid = rvalid_q;
    assign rdata  = rdata_q;
    assign rresp  = RESP_OKAY;

    // Write response: raised after a taken write, dropped once accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bvalid_q <= 1'b0;
            bresp_q  <= RESP_OKAY;
        end else if (wr_fire_o) begin
            bvalid_q <= 1'b1;
            bresp_q  <= wr_err_i ? RESP_SLVERR : RESP_OKAY;
        end else if (bready) begin
            bvalid_q <= 1'b0;
        end
    end

    // Read response: capture the selected data on the address handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else if (rd_fire_o) begin
            rvalid_q <= 1'b1;
            rdata_q  <= rd_data_i;
        end else if (rready) begin
            rvalid_q <= 1'b0;
        end
    end

    AST_WR_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        (awready || wready) |-> (awvalid && wvalid && awready && wready)); // R2
    AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid && !bready) |=> (bvalid && $stable(bresp))); // R4
    AST_R_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && !rready) |=> (rvalid && $stable(rdata))); // R4
    AST_RRESP_OKAY: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> (rresp == RESP_OKAY)); // R5

endmodule

// File: rtl/spi_rf_irq.sv
// Interrupt registers: global gate (bit 31), pending flags and mask.
// Software inverts a pending flag by writing a 1 to it. An event strobe
// sets its flag and wins over an inversion in the same cycle. Assumes
// IRQ_N <= 31, so that the flags do not overlap the gate bit.
module spi_rf_irq #(
    parameter int IRQ_N = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_rst_i,
    input  logic             wr_gie_i,
    input  logic             wr_isr_i,
    input  logic             wr_ier_i,
    input  logic [31:0]      wdata_i,
    input  logic [IRQ_N-1:0] evt_i,
    output logic             gie_o,
    output logic [IRQ_N-1:0] isr_o,
    output logic [IRQ_N-1:0] ier_o,
    output logic             irq_o
);

    logic             gie_q;
    logic [IRQ_N-1:0] isr_q;
    logic [IRQ_N-1:0] ier_q;
    logic [IRQ_N-1:0] flip;
    logic [IRQ_N-1:0] isr_d;
    logic             unused_wbits;

    assign unused_wbits = ^wdata_i[30:IRQ_N];

    // Next pending value: inversion by software, then set by events.
    always_comb begin
        flip  = wr_isr_i ? wdata_i[IRQ_N-1:0] : '0;
        isr_d = (isr_q ^ flip) | evt_i;
    end

    // Pending flags.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst_i) isr_q <= '0;
        else                    isr_q <= isr_d;
    end

    // Mask and global gate.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst_i) begin
            ier_q <= '0;
            gie_q <= 1'b0;
        end else begin
            if (wr_ier_i) ier_q <= wdata_i[IRQ_N-1:0];
            if (wr_gie_i) gie_q <= wdata_i[31];
        end
    end

    assign gie_o = gie_q;
    assign isr_o = isr_q;
    assign ier_o = ier_q;
    assign irq_o = gie_q && |(isr_q & ier_q);

    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_rst_i |=> ((isr_q & $past(evt_i)) == $past(evt_i))); // R10
    AST_ISR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_rst_i && !wr_isr_i && (evt_i == '0)) |=> $stable(isr_q)); // R9

endmodule

// File: rtl/spi_regfront.sv
// SPI master register front-end. Holds control, chip-select and interrupt
// registers behind an AXI4-Lite slave. Reads engine state from sideband
// inputs and sends push, pop and software-reset strobes to the engine.
// Assumes full-word access; byte strobes are ignored.
module spi_regfront
    import spi_rf_pkg::*;
#(
    parameter int          ADDR_W     = 7,
    parameter int          CTRL_W     = 10,
    parameter int          SS_W       = 4,
    parameter int          STAT_W     = 11,
    parameter int          IRQ_N      = 8,
    parameter int          FIFO_DEPTH = 16,
    parameter int          OCC_W      = $clog2(FIFO_DEPTH) + 1,
    parameter logic [31:0] CTRL_RST   = 32'h0000_0180
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              awvalid,
    output logic              awready,
    input  logic [31:0]       wdata,
    input  logic [3:0]        wstrb,
    input  logic              wvalid,
    output logic              wready,
    output logic [1:0]        bresp,
    output logic              bvalid,
    input  logic              bready,
    input  logic [ADDR_W-1:0] araddr,
    input  logic              arvalid,
    output logic              arready,
    output logic [31:0]       rdata,
    output logic [1:0]        rresp,
    output logic              rvalid,
    input  logic              rready,
    input  logic [STAT_W-1:0] stat_i,
    input  logic [OCC_W-1:0]  tx_occ_i,
    input  logic [OCC_W-1:0]  rx_occ_i,
    input  logic [31:0]       rx_data_i,
    input  logic [IRQ_N-1:0]  irq_evt_i,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [SS_W-1:0]   ssel_o,
    output logic              tx_wr_o,
    output logic [31:0]       tx_data_o,
    output logic              rx_rd_o,
    output logic              soft_rst_o,
    output logic              irq_o
);

    localparam bit                OCC_EN     = (FIFO_DEPTH == 16) || (FIFO_DEPTH == 256);
    localparam logic [CTRL_W-1:0] CTRL_DFLT  = CTRL_RST[CTRL_W-1:0];

    reg_sel_e          wr_sel;
    reg_sel_e          rd_sel;
    logic              wr_fire;
    logic              rd_fire;
    logic              wr_err;
    logic              sw_rst;
    logic [31:0]       rd_mux;
    logic [CTRL_W-1:0] ctrl_q;
    logic [SS_W-1:0]   ssel_q;
    logic              soft_rst_q;
    logic              gie;
    logic [IRQ_N-1:0]  isr;
    logic [IRQ_N-1:0]  ier;
    logic              unused_strb;

    assign unused_strb = ^wstrb;

    spi_rf_decode #(.ADDR_W(ADDR_W), .OCC_EN(OCC_EN)) u_wdec (
        .addr (awaddr),
        .sel  (wr_sel)
    );

    spi_rf_decode #(.ADDR_W(ADDR_W), .OCC_EN(OCC_EN)) u_rdec (
        .addr (araddr),
        .sel  (rd_sel)
    );

    spi_rf_axi u_axi (
        .clk       (clk),
        .rst_n     (rst_n),
        .awvalid   (awvalid),
        .wvalid    (wvalid),
        .awready   (awready),
        .wready    (wready),
        .bresp     (bresp),
        .bvalid    (bvalid),
        .bready    (bready),
        .arvalid   (arvalid),
        .arready   (arready),
        .rdata     (rdata),
        .rresp     (rresp),
        .rvalid    (rvalid),
        .rready    (rready),
        .wr_err_i  (wr_err),
        .rd_data_i (rd_mux),
        .wr_fire_o (wr_fire),
        .rd_fire_o (rd_fire)
    );

    // Software-reset key check and error response for a wrong key.
    always_comb begin
        sw_rst = wr_fire && (wr_sel == SEL_SRST) && (wdata == SRST_KEY);
        wr_err = (wr_sel == SEL_SRST) && (wdata != SRST_KEY);
    end

    spi_rf_irq #(.IRQ_N(IRQ_N)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_rst_i (sw_rst),
        .wr_gie_i (wr_fire && (wr_sel == SEL_GIE)),
        .wr_isr_i (wr_fire && (wr_sel == SEL_ISR)),
        .wr_ier_i (wr_fire && (wr_sel == SEL_IER)),
        .wdata_i  (wdata),
        .evt_i    (irq_evt_i),
        .gie_o    (gie),
        .isr_o    (isr),
        .ier_o    (ier),
        .irq_o    (irq_o)
    );

    // Control and chip-select registers.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst) begin
            ctrl_q <= CTRL_DFLT;
            ssel_q <= '1;
        end else if (wr_fire) begin
            if (wr_sel == SEL_CTRL) ctrl_q <= wdata[CTRL_W-1:0];
            if (wr_sel == SEL_SSEL) ssel_q <= wdata[SS_W-1:0];
        end
    end

    // Software-reset pulse, one cycle after the key is written.
    always_ff @(posedge clk) begin
        if (!rst_n) soft_rst_q <= 1'b0;
        else        soft_rst_q <= sw_rst;
    end

    // Read data selection; write-only and unmapped offsets read zero.
    always_comb begin
        rd_mux = '0;
        case (rd_sel)
            SEL_CTRL:  rd_mux = 32'(ctrl_q);
            SEL_STAT:  rd_mux = 32'(stat_i);
            SEL_RXD:   rd_mux = rx_data_i;
            SEL_SSEL:  rd_mux = 32'(ssel_q);
            SEL_TXOCC: rd_mux = 32'(tx_occ_i);
            SEL_RXOCC: rd_mux = 32'(rx_occ_i);
            SEL_GIE:   rd_mux = {gie, 31'b0};
            SEL_ISR:   rd_mux = 32'(isr);
            SEL_IER:   rd_mux = 32'(ier);
            default:   rd_mux = '0;
        endcase
    end

    assign ctrl_o     = ctrl_q;
    assign ssel_o     = ssel_q;
    assign tx_wr_o    = wr_fire && (wr_sel == SEL_TXD);
    assign tx_data_o  = wdata;
    assign rx_rd_o    = rd_fire && (rd_sel == SEL_RXD);
    assign soft_rst_o = soft_rst_q;

    AST_SRST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |=> !soft_rst_o); // R13
    AST_SRST_DFLT: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |-> ((ctrl_o == CTRL_DFLT) && (ssel_o == '1) && !irq_o)); // R13
    AST_TX_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr_o |-> (awvalid && wvalid && awready)); // R12
    AST_RX_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rd_o |-> (arvalid && arready)); // R12

endmodule

// File: tb/tb_spi_regfront.sv
module tb_spi_regfront;

    localparam int CLK_PERIOD = 10;
    localparam int IRQ_N      = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  awaddr = '0;
    logic        awvalid = 1'b0;
    logic [31:0] wdata = '0;
    logic [3:0]  wstrb = '0;
    logic        wvalid = 1'b0;
    logic        bready = 1'b0;
    logic [6:0]  araddr = '0;
    logic        arvalid = 1'b0;
    logic        rready = 1'b0;
    logic [10:0] stat_in = 11'h0A5;
    logic [4:0]  tx_occ = 5'd9;
    logic [4:0]  rx_occ = 5'd16;
    logic [3:0]  tx_occ_s = 4'd3;
    logic [3:0]  rx_occ_s = 4'd2;
    logic [31:0] rx_word = 32'hDEAD_BEEF;
    logic [IRQ_N-1:0] irq_evt = '0;

    logic        awready, wready, bvalid, arready, rvalid;
    logic [1:0]  bresp, rresp;
    logic [31:0] rdata;
    logic [9:0]  ctrl;
    logic [3:0]  ssel;
    logic        tx_wr, rx_rd, soft_rst, irq;
    logic [31:0] tx_data;

    logic        awready_s, wready_s, bvalid_s, arready_s, rvalid_s;
    logic [1:0]  bresp_s, rresp_s;
    logic [31:0] rdata_s, tx_data_s;
    logic [9:0]  ctrl_s;
    logic [3:0]  ssel_s;
    logic        tx_wr_s, rx_rd_s, soft_rst_s, irq_s;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic        hs_tx_wr, hs_rx_rd, seen_srst;
    logic [31:0] hs_tx_data, last_small;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_regfront dut (
        .clk(clk), .rst_n(rst_n), .awaddr(awaddr), .awvalid(awvalid), .awready(awready),
        .wdata(wdata), .wstrb(wstrb), .wvalid(wvalid), .wready(wready), .bresp(bresp),
        .bvalid(bvalid), .bready(bready), .araddr(araddr), .arvalid(arvalid),
        .arready(arready), .rdata(rdata), .rresp(rresp), .rvalid(rvalid), .rready(rready),
        .stat_i(stat_in), .tx_occ_i(tx_occ), .rx_occ_i(rx_occ), .rx_data_i(rx_word),
        .irq_evt_i(irq_evt), .ctrl_o(ctrl), .ssel_o(ssel), .tx_wr_o(tx_wr),
        .tx_data_o(tx_data), .rx_rd_o(rx_rd), .soft_rst_o(soft_rst), .irq_o(irq)
    );

    spi_regfront #(.FIFO_DEPTH(8)) dut_small (
        .clk(clk), .rst_n(rst_n), .awaddr(awaddr), .awvalid(awvalid), .awready(awready_s),
        .wdata(wdata), .wstrb(wstrb), .wvalid(wvalid), .wready(wready_s), .bresp(bresp_s),
        .bvalid(bvalid_s), .bready(bready), .araddr(araddr), .arvalid(arvalid),
        .arready(arready_s), .rdata(rdata_s), .rresp(rresp_s), .rvalid(rvalid_s),
        .rready(rready), .stat_i(stat_in), .tx_occ_i(tx_occ_s), .rx_occ_i(rx_occ_s),
        .rx_data_i(rx_word), .irq_evt_i(irq_evt), .ctrl_o(ctrl_s), .ssel_o(ssel_s),
        .tx_wr_o(tx_wr_s), .tx_data_o(tx_data_s), .rx_rd_o(rx_rd_s),
        .soft_rst_o(soft_rst_s), .irq_o(irq_s)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic axi_wr(input logic [6:0] a, input logic [31:0] d, input logic [3:0] s,
                          input logic [IRQ_N-1:0] ev, output logic [1:0] resp);
        @(negedge clk);
        awaddr = a; wdata = d; wstrb = s; awvalid = 1'b1; wvalid = 1'b1; irq_evt = ev;
        #1;
        hs_tx_wr = tx_wr; hs_tx_data = tx_data;
        @(posedge clk);
        @(negedge clk);
        awvalid = 1'b0; wvalid = 1'b0; irq_evt = '0; bready = 1'b1;
        seen_srst = soft_rst;
        while (!bvalid) @(negedge clk);
        resp = bresp;
        @(posedge clk);
        @(negedge clk);
        bready = 1'b0;
    endtask

    task automatic axi_rd(input logic [6:0] a, output logic [31:0] d, output logic [1:0] resp);
        @(negedge clk);
        araddr = a; arvalid = 1'b1;
        #1;
        hs_rx_rd = rx_rd;
        @(posedge clk);
        @(negedge clk);
        arvalid = 1'b0; rready = 1'b1;
        while (!rvalid) @(negedge clk);
        d = rdata; resp = rresp; last_small = rdata_s;
        @(posedge clk);
        @(negedge clk);
        rready = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d; logic [1:0] r;
        @(negedge clk);
        chk("R1 bvalid", 32'(bvalid), 0);
        chk("R1 rvalid", 32'(rvalid), 0);
        chk("R1 irq_o", 32'(irq), 0);
        axi_rd(7'h60, d, r); chk("R1 ctrl", d, 32'h180);
        axi_rd(7'h70, d, r); chk("R1 ssel", d, 32'hF);
        axi_rd(7'h1C, d, r); chk("R1 gie", d, 0);
        axi_rd(7'h20, d, r); chk("R1 isr", d, 0);
        axi_rd(7'h28, d, r); chk("R1 ier", d, 0);
    endtask

    task automatic t_lone_channel();
        logic [31:0] d; logic [1:0] r; logic seen = 1'b0;
        @(negedge clk);
        awaddr = 7'h60; wdata = 32'h3; awvalid = 1'b1;
        for (int i = 0; i < 3; i++) begin
            #1; seen = seen | awready | wready | bvalid;
            @(negedge clk);
        end
        awvalid = 1'b0; wvalid = 1'b1;
        for (int i = 0; i < 3; i++) begin
            #1; seen = seen | awready | wready | bvalid;
            @(negedge clk);
        end
        wvalid = 1'b0;
        chk("R2 lone channel taken", 32'(seen), 0);
        axi_rd(7'h60, d, r); chk("R2 ctrl after lone channel", d, 32'h180);
        axi_wr(7'h60, 32'h0000_02AB, 4'h0, '0, r);
        chk("R2 paired write resp", 32'(r), 0);
        axi_rd(7'h60, d, r); chk("R3 ctrl with wstrb 0", d, 32'h2AB);
        chk("R3 ctrl_o", 32'(ctrl), 32'h2AB);
        axi_wr(7'h70, 32'h0000_0005, 4'h1, '0, r);
        axi_rd(7'h70, d, r); chk("R3 ssel", d, 32'h5);
    endtask

    task automatic t_backpressure();
        logic ok = 1'b1;
        @(negedge clk);
        araddr = 7'h64; arvalid = 1'b1;
        @(negedge clk);
        arvalid = 1'b0;
        chk("R4 rvalid one cycle after handshake", 32'(rvalid), 1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            ok = ok & rvalid & (rdata == 32'h0A5);
        end
        chk("R4 rvalid held without rready", 32'(ok), 1);
        rready = 1'b1;
        @(negedge clk);
        rready = 1'b0;
        chk("R4 rvalid drops after rready", 32'(rvalid), 0);
    endtask

    task automatic t_unmapped_ro();
        logic [31:0] d; logic [1:0] r;
        axi_rd(7'h30, d, r); chk("R5 unmapped data", d, 0); chk("R5 unmapped resp", 32'(r), 0);
        axi_wr(7'h7C, 32'hFFFF_FFFF, 4'hF, '0, r); chk("R5 unmapped write resp", 32'(r), 0);
        axi_rd(7'h60, d, r); chk("R5 ctrl unchanged", d, 32'h2AB);
        axi_wr(7'h64, 32'hFFFF_FFFF, 4'hF, '0, r);
        axi_rd(7'h64, d, r); chk("R6 status", d, 32'h0A5);
        axi_wr(7'h6C, 32'h1111_1111, 4'hF, '0, r);
        axi_rd(7'h6C, d, r); chk("R6 rx data", d, 32'hDEAD_BEEF);
        chk("R12 rx_rd_o on pop", 32'(hs_rx_rd), 1);
        axi_rd(7'h74, d, r); chk("R6 tx occupancy", d, 32'd9);
        chk("R8 small depth tx occupancy", last_small, 0);
        axi_rd(7'h78, d, r); chk("R6 rx occupancy", d, 32'd16);
        chk("R8 small depth rx occupancy", last_small, 0);
        axi_wr(7'h68, 32'h1234_5678, 4'h0, '0, r);
        chk("R12 tx_wr_o", 32'(hs_tx_wr), 1);
        chk("R12 tx_data_o", hs_tx_data, 32'h1234_5678);
        axi_rd(7'h68, d, r); chk("R7 tx data reads zero", d, 0);
        chk("R12 no pop on other read", 32'(hs_rx_rd), 0);
        axi_rd(7'h40, d, r); chk("R7 reset offset reads zero", d, 0);
    endtask

    task automatic t_irq();
        logic [31:0] d; logic [1:0] r;
        axi_wr(7'h28, 32'h0000_0003, 4'hF, '0, r);
        axi_wr(7'h20, 32'h0000_0001, 4'hF, '0, r);
        axi_rd(7'h20, d, r); chk("R9 toggle sets", d, 32'h1);
        chk("R11 no irq without gate", 32'(irq), 0);
        axi_wr(7'h1C, 32'h8000_0000, 4'hF, '0, r);
        axi_rd(7'h1C, d, r); chk("R11 gate reads", d, 32'h8000_0000);
        chk("R11 irq with gate", 32'(irq), 1);
        axi_wr(7'h20, 32'h0000_0001, 4'hF, '0, r);
        axi_rd(7'h20, d, r); chk("R9 toggle clears", d, 0);
        chk("R11 irq drops", 32'(irq), 0);
        @(negedge clk); irq_evt = 8'h04;
        @(negedge clk); irq_evt = '0;
        axi_rd(7'h20, d, r); chk("R10 event sets", d, 32'h4);
        chk("R11 masked event no irq", 32'(irq), 0);
        @(negedge clk); irq_evt = 8'h02;
        @(negedge clk); irq_evt = '0;
        chk("R11 irq from event", 32'(irq), 1);
        axi_wr(7'h20, 32'h0000_0002, 4'hF, 8'h02, r);
        axi_rd(7'h20, d, r); chk("R10 event beats toggle", d, 32'h6);
        axi_wr(7'h20, 32'h0000_0006, 4'hF, '0, r);
        axi_rd(7'h20, d, r); chk("R9 multi toggle", d, 0);
    endtask

    task automatic t_soft_reset();
        logic [31:0] d; logic [1:0] r;
        axi_wr(7'h60, 32'h0000_03FF, 4'hF, '0, r);
        axi_wr(7'h70, 32'h0, 4'hF, '0, r);
        axi_wr(7'h40, 32'h0000_0005, 4'hF, '0, r);
        chk("R13 wrong key SLVERR", 32'(r), 32'h2);
        chk("R13 no pulse on wrong key", 32'(seen_srst), 0);
        axi_rd(7'h60, d, r); chk("R13 ctrl kept on wrong key", d, 32'h3FF);
        axi_wr(7'h40, 32'h0000_000A, 4'hF, '0, r);
        chk("R13 key OKAY", 32'(r), 0);
        chk("R13 pulse", 32'(seen_srst), 1);
        chk("R13 pulse one cycle", 32'(soft_rst), 0);
        axi_rd(7'h60, d, r); chk("R13 ctrl default", d, 32'h180);
        axi_rd(7'h70, d, r); chk("R13 ssel default", d, 32'hF);
        axi_rd(7'h28, d, r); chk("R13 ier default", d, 0);
        axi_rd(7'h1C, d, r); chk("R13 gate default", d, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_lone_channel();
        t_backpressure();
        t_unmapped_ro();
        t_irq();
        t_soft_reset();
        done = 1'b1;
        summary();
        $finish;
    end

endmodule